// File: doc/BRIEF.md
# SASI Host Adapter Register Interface

This block connects a byte-wide CPU bus to a SASI disk-controller bus through four byte registers. The host picks a register with a two-bit index and strobes a read or a write. Index 0 moves data bytes over the bus. Index 1 reads back a status byte, and a write to it resets the bus. Index 2 reads as a fixed configuration byte, and a write to it starts target selection. Index 3 holds the interrupt mask.

Each access to the data register runs one REQ/ACK handshake. ACK rises in the cycle after the access and falls once the target drops REQ. A timeout counter returns the handshake to idle if REQ never falls. A data read made in the status phase also takes the following message byte in a second handshake and discards it.

Two interrupt sources share one output, each with its own mask bit. The first is a data-phase request that is reported live. The second is a command-complete flag. The flag is set when the byte after a host data transfer is requested in the status phase, and it is cleared by reading the status register.

Top module: `sasi_host_if`

## Requirements
- R1: After reset, rd_data is 0x00, and irq, bus_ack, bus_sel, bus_rst and bus_data_oe are all low.
- R2: The status byte (read at index 1) has bits 7 and 6 at 1 and bit 3 equal to BSY. Bits 0, 1 and 2 equal REQ, I/O and C/D while BSY is high, and read 0 while BSY is low.
- R3: Status bit 4 is 1 exactly when BSY is high, C/D is low (data-in phase has I/O=1, data-out phase has I/O=0) and mask bit 0 is set.
- R4: Status bit 5 shows the command-complete flag. A status read returns the flag's old value and clears it. If a set falls in the same cycle as the clearing read, the set wins.
- R5: When a single-byte data handshake has completed, the next rising REQ is checked. If that REQ comes with BSY, C/D and I/O all high (status phase) and mask bit 1 is set, the command-complete flag is set.
- R6: A data read (index 0) returns the bus data sampled at the strobe on rd_data in the next cycle. It asserts bus_ack from that cycle until the cycle after REQ is seen low.
- R7: A data write (index 0) drives the written byte on bus_data_out, with bus_data_oe high, for as long as bus_ack is high.
- R8: A data read that starts in the status phase returns the status byte. It then acknowledges one more byte on the next REQ without changing rd_data, and it does not lead to a command-complete flag.
- R9: A write to index 1 asserts bus_rst for RST_CYCLES cycles, clears the mask to 0x00 and aborts any handshake in progress.
- R10: A write to index 2 drives 0x01 on the bus data, with bus_data_oe high, and asserts bus_sel for SEL_CYCLES cycles, after which both are released.
- R11: A read of index 2 returns 0xFF. A read of index 3 returns 0x00.
- R12: A write to index 3 stores the byte as the interrupt mask. Bit 0 enables the data-request source and bit 1 enables command-complete.
- R13: irq is high while the command-complete flag is set, or while BSY is high, C/D is low, REQ is high and mask bit 0 is set.
- R14: If REQ stays high, bus_ack is released after TIMEOUT_CYCLES cycles and the handshake returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_sel | input | 2 | Register index |
| rd_stb | input | 1 | Host read strobe, one cycle |
| wr_stb | input | 1 | Host write strobe, one cycle |
| wr_data | input | 8 | Host write byte |
| rd_data | output | 8 | Registered host read byte |
| irq | output | 1 | Interrupt request |
| bus_data_in | input | 8 | Data lines from the target |
| bus_data_out | output | 8 | Data lines to the target |
| bus_data_oe | output | 1 | Drive enable for bus_data_out |
| bus_sel | output | 1 | Selection line |
| bus_rst | output | 1 | Bus reset line |
| bus_ack | output | 1 | Acknowledge line |
| bus_bsy | input | 1 | Target busy |
| bus_req | input | 1 | Target byte request |
| bus_io | input | 1 | Direction, 1 = target to host |
| bus_cd | input | 1 | 1 = command or status phase |

## Verification
A status-register read and the setting of the command-complete flag can fall in the same cycle. Both then act on the flag: the read clears it and the event sets it. The bench provokes this by completing a data write and then, at one clock edge, raising REQ in the status phase together with a status read strobe. It judges the result in two ways. The read must return bit 5 clear while irq rises. A second status read must then return bit 5 set, which shows that the event was not lost.

// File: rtl/sasi_pkg.sv
package sasi_pkg;
    localparam int DATA_W = 8;

    localparam logic [1:0] IDX_DATA = 2'd0;
    localparam logic [1:0] IDX_CTRL = 2'd1;
    localparam logic [1:0] IDX_CFG  = 2'd2;
    localparam logic [1:0] IDX_MASK = 2'd3;

    localparam logic [DATA_W-1:0] SELECT_ID = 8'h01;
    localparam logic [DATA_W-1:0] CFG_VALUE = 8'hFF;

    // mask bit positions
    localparam int MSK_DREQ = 0;
    localparam int MSK_DONE = 1;

    typedef enum logic [1:0] {
        HS_IDLE,
        HS_ACK,
        HS_GAP,
        HS_ACK2
    } hs_state_e;
endpackage

// File: rtl/sasi_pulse.sv
module sasi_pulse #(
    parameter int CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    output logic active
);
    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (fire)
            cnt_d = CW'(CYCLES);
        else if (cnt_q != '0)
            cnt_d = cnt_q - CW'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign active = (cnt_q != '0);
endmodule

// File: rtl/sasi_handshake.sv
module sasi_handshake
    import sasi_pkg::*;
#(
    parameter int TIMEOUT = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic two_byte,
    input  logic abort,
    input  logic req,
    output logic ack,
    output logic idle,
    output logic done
);
    localparam int TW = $clog2(TIMEOUT + 1);

    typedef struct packed {
        hs_state_e     st;
        logic          two;
        logic [TW-1:0] cnt;
    } hs_t;

    hs_t q, d;

    always_comb begin
        d    = q;
        done = 1'b0;
        unique case (q.st)
            HS_IDLE: if (start) begin
                d.st  = HS_ACK;
                d.two = two_byte;
                d.cnt = '0;
            end
            HS_ACK: if (!req) begin
                d.cnt = '0;
                if (q.two) begin
                    d.st = HS_GAP;
                end else begin
                    d.st = HS_IDLE;
                    done = 1'b1;
                end
            end
            HS_GAP: if (req) begin
                d.st  = HS_ACK2;
                d.cnt = '0;
            end
            HS_ACK2: if (!req) begin
                d.st  = HS_IDLE;
                d.cnt = '0;
            end
            default: d.st = HS_IDLE;
        endcase

        if (q.st != HS_IDLE && d.st == q.st) begin
            if (q.cnt == TW'(TIMEOUT - 1)) begin
                d.st  = HS_IDLE;
                d.cnt = '0;
            end else begin
                d.cnt = q.cnt + TW'(1);
            end
        end

        if (abort) begin
            d.st  = HS_IDLE;
            d.cnt = '0;
            done  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.st  <= HS_IDLE;
            q.two <= 1'b0;
            q.cnt <= '0;
        end else begin
            q <= d;
        end
    end

    assign ack  = (q.st == HS_ACK) || (q.st == HS_ACK2);
    assign idle = (q.st == HS_IDLE);
endmodule

// File: rtl/sasi_status_gen.sv
module sasi_status_gen
    import sasi_pkg::*;
(
    input  logic              bsy,
    input  logic              req,
    input  logic              io,
    input  logic              cd,
    input  logic              dreq_en,
    input  logic              pend,
    output logic [DATA_W-1:0] status
);
    logic [2:0] phase_bits;

    always_comb begin
        phase_bits = bsy ? {cd, io, req} : 3'b000;
        status     = {2'b11, pend, bsy & ~cd & dreq_en, bsy, phase_bits};
    end
endmodule

// File: rtl/sasi_host_if.sv
module sasi_host_if
    import sasi_pkg::*;
#(
    parameter int TIMEOUT_CYCLES = 64,
    parameter int SEL_CYCLES     = 4,
    parameter int RST_CYCLES     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        reg_sel,
    input  logic              rd_stb,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq,
    input  logic [DATA_W-1:0] bus_data_in,
    output logic [DATA_W-1:0] bus_data_out,
    output logic              bus_data_oe,
    output logic              bus_sel,
    output logic              bus_rst,
    output logic              bus_ack,
    input  logic              bus_bsy,
    input  logic              bus_req,
    input  logic              bus_io,
    input  logic              bus_cd
);
    typedef struct packed {
        logic [DATA_W-1:0] mask;
        logic              pend;
        logic [DATA_W-1:0] rdata;
        logic [DATA_W-1:0] dout;
        logic              wr_dir;
        logic              arm;
        logic              req_prev;
    } regs_t;

    regs_t q, d;

    logic              data_rd, data_wr, ctrl_rd, ctrl_wr, cfg_wr;
    logic              status_phase, req_rise, done_set;
    logic              hs_start, hs_ack, hs_idle, hs_done;
    logic              sel_active, rst_active;
    logic [DATA_W-1:0] status_byte;

    assign data_rd      = rd_stb && (reg_sel == IDX_DATA);
    assign data_wr      = wr_stb && (reg_sel == IDX_DATA);
    assign ctrl_rd      = rd_stb && (reg_sel == IDX_CTRL);
    assign ctrl_wr      = wr_stb && (reg_sel == IDX_CTRL);
    assign cfg_wr       = wr_stb && (reg_sel == IDX_CFG);
    assign status_phase = bus_bsy && bus_cd && bus_io;
    assign req_rise     = bus_req && !q.req_prev;
    assign hs_start     = (data_rd || data_wr) && hs_idle;
    assign done_set     = q.arm && req_rise && status_phase && q.mask[MSK_DONE];

    sasi_status_gen u_status (
        .bsy     (bus_bsy),
        .req     (bus_req),
        .io      (bus_io),
        .cd      (bus_cd),
        .dreq_en (q.mask[MSK_DREQ]),
        .pend    (q.pend),
        .status  (status_byte)
    );

    sasi_handshake #(.TIMEOUT(TIMEOUT_CYCLES)) u_hs (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (hs_start),
        .two_byte (status_phase),
        .abort    (ctrl_wr),
        .req      (bus_req),
        .ack      (hs_ack),
        .idle     (hs_idle),
        .done     (hs_done)
    );

    sasi_pulse #(.CYCLES(SEL_CYCLES)) u_sel_pulse (
        .clk    (clk),
        .rst_n  (rst_n),
        .fire   (cfg_wr),
        .active (sel_active)
    );

    sasi_pulse #(.CYCLES(RST_CYCLES)) u_rst_pulse (
        .clk    (clk),
        .rst_n  (rst_n),
        .fire   (ctrl_wr),
        .active (rst_active)
    );

    always_comb begin
        d          = q;
        d.req_prev = bus_req;

        if (rd_stb) begin
            unique case (reg_sel)
                IDX_DATA: d.rdata = bus_data_in;
                IDX_CTRL: d.rdata = status_byte;
                IDX_CFG:  d.rdata = CFG_VALUE;
                default:  d.rdata = '0;
            endcase
        end

        if (wr_stb) begin
            unique case (reg_sel)
                IDX_DATA: if (hs_idle) d.dout = wr_data;
                IDX_CTRL: d.mask = '0;
                IDX_MASK: d.mask = wr_data;
                default:  ;
            endcase
        end

        if (hs_start)
            d.wr_dir = data_wr;

        if (req_rise || !bus_bsy || ctrl_wr)
            d.arm = 1'b0;
        if (hs_done && bus_bsy)
            d.arm = 1'b1;

        // a new event outranks a clearing read in the same cycle
        d.pend = done_set || (q.pend && !ctrl_rd);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign rd_data      = q.rdata;
    assign bus_ack      = hs_ack;
    assign bus_sel      = sel_active;
    assign bus_rst      = rst_active;
    assign bus_data_oe  = sel_active || (hs_ack && q.wr_dir);
    assign bus_data_out = sel_active ? SELECT_ID : q.dout;
    assign irq          = q.pend ||
                          (bus_bsy && !bus_cd && bus_req && q.mask[MSK_DREQ]);
endmodule

// File: rtl/sasi_host_if_chk.sv
module sasi_host_if_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] reg_sel,
    input logic       rd_stb,
    input logic       wr_stb,
    input logic [7:0] rd_data,
    input logic       bus_ack,
    input logic       bus_req,
    input logic       bus_sel,
    input logic       bus_rst,
    input logic [7:0] bus_data_out,
    input logic       bus_data_oe
);
    assert_status_ones_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && reg_sel == 2'd1) |=> (rd_data[7:6] == 2'b11));

    assert_cfg_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && reg_sel == 2'd2) |=> (rd_data == 8'hFF));

    assert_mask_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && reg_sel == 2'd3) |=> (rd_data == 8'h00));

    assert_ack_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_ack && !bus_req) |=> !bus_ack);

    assert_reset_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && reg_sel == 2'd1) |=> (bus_rst && !bus_ack));

    assert_select_drive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && reg_sel == 2'd2) |=> (bus_sel && bus_data_oe && bus_data_out == 8'h01));
endmodule

bind sasi_host_if sasi_host_if_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_sel      (reg_sel),
    .rd_stb       (rd_stb),
    .wr_stb       (wr_stb),
    .rd_data      (rd_data),
    .bus_ack      (bus_ack),
    .bus_req      (bus_req),
    .bus_sel      (bus_sel),
    .bus_rst      (bus_rst),
    .bus_data_out (bus_data_out),
    .bus_data_oe  (bus_data_oe)
);

// File: tb/sasi_host_if_bench.sv
`timescale 1ns/1ps
module sasi_host_if_bench;
    localparam int TO_CYC  = 64;
    localparam int SEL_CYC = 4;
    localparam int RST_CYC = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] reg_sel = 2'd0;
    logic       rd_stb = 1'b0;
    logic       wr_stb = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       irq;
    logic [7:0] bus_data_in = 8'h00;
    logic [7:0] bus_data_out;
    logic       bus_data_oe, bus_sel, bus_rst, bus_ack;
    logic       bus_bsy = 1'b0;
    logic       bus_req = 1'b0;
    logic       bus_io = 1'b0;
    logic       bus_cd = 1'b0;

    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    sasi_host_if u_sasi_host_if (
        .clk (clk), .rst_n (rst_n), .reg_sel (reg_sel), .rd_stb (rd_stb),
        .wr_stb (wr_stb), .wr_data (wr_data), .rd_data (rd_data), .irq (irq),
        .bus_data_in (bus_data_in), .bus_data_out (bus_data_out),
        .bus_data_oe (bus_data_oe), .bus_sel (bus_sel), .bus_rst (bus_rst),
        .bus_ack (bus_ack), .bus_bsy (bus_bsy), .bus_req (bus_req),
        .bus_io (bus_io), .bus_cd (bus_cd)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic host_rd(input logic [1:0] idx);
        reg_sel = idx; rd_stb = 1'b1;
        step();
        rd_stb = 1'b0;
    endtask

    task automatic host_wr(input logic [1:0] idx, input logic [7:0] val);
        reg_sel = idx; wr_data = val; wr_stb = 1'b1;
        step();
        wr_stb = 1'b0;
    endtask

    task automatic bus_set(input logic b, input logic c, input logic i, input logic r);
        bus_bsy = b; bus_cd = c; bus_io = i; bus_req = r;
    endtask

    task automatic bus_idle();
        bus_set(0, 0, 0, 0);
        step(); step();
    endtask

    task automatic t_reset();
        chk("R1 rd_data", rd_data, 8'h00);
        chk("R1 irq", irq, 0);
        chk("R1 ack", bus_ack, 0);
        chk("R1 sel", bus_sel, 0);
        chk("R1 rst", bus_rst, 0);
        chk("R1 oe", bus_data_oe, 0);
    endtask

    task automatic t_status();
        bus_set(0, 1, 1, 1);
        host_rd(2'd1);
        chk("R2 idle status", rd_data, 8'hC0);
        bus_set(1, 0, 1, 1);
        host_rd(2'd1);
        chk("R2 data-in status", rd_data, 8'hCB);
        bus_set(1, 1, 0, 0);
        host_rd(2'd1);
        chk("R2 command status", rd_data, 8'hCC);
        bus_idle();
    endtask

    task automatic t_mask_dreq();
        host_wr(2'd3, 8'h01);
        bus_set(1, 0, 0, 0);
        step();
        chk("R13 no req no irq", irq, 0);
        host_rd(2'd1);
        chk("R3 R12 data-out status", rd_data, 8'hD8);
        bus_req = 1'b1;
        step();
        chk("R13 dreq irq", irq, 1);
        bus_cd = 1'b1;
        step();
        chk("R13 command phase no irq", irq, 0);
        bus_cd = 1'b0;
        host_wr(2'd3, 8'h00);
        chk("R12 mask cleared irq", irq, 0);
        host_rd(2'd1);
        chk("R3 bit4 off with mask0", rd_data[4], 0);
        bus_idle();
    endtask

    task automatic t_config();
        host_rd(2'd2);
        chk("R11 config", rd_data, 8'hFF);
        host_wr(2'd3, 8'h55);
        host_rd(2'd3);
        chk("R11 reg3 reads zero", rd_data, 8'h00);
        host_wr(2'd3, 8'h00);
    endtask

    task automatic t_data_read();
        bus_set(1, 0, 1, 1);
        bus_data_in = 8'h5A;
        host_rd(2'd0);
        chk("R6 read data", rd_data, 8'h5A);
        chk("R6 ack up", bus_ack, 1);
        chk("R7 no drive on read", bus_data_oe, 0);
        step();
        chk("R6 ack held", bus_ack, 1);
        bus_req = 1'b0;
        step();
        chk("R6 ack released", bus_ack, 0);
        bus_idle();
    endtask

    task automatic t_write_done();
        host_wr(2'd3, 8'h02);
        bus_set(1, 0, 0, 1);
        host_wr(2'd0, 8'hA5);
        chk("R7 ack", bus_ack, 1);
        chk("R7 oe", bus_data_oe, 1);
        chk("R7 data", bus_data_out, 8'hA5);
        bus_req = 1'b0;
        step();
        chk("R7 released", {bus_ack, bus_data_oe}, 2'b00);
        chk("R5 no irq before status", irq, 0);
        bus_set(1, 1, 1, 1);
        step();
        chk("R5 command complete irq", irq, 1);
        host_rd(2'd1);
        chk("R4 status shows flag", rd_data, 8'hEF);
        chk("R4 read clears flag", irq, 0);
    endtask

    task automatic t_status_read();
        bus_data_in = 8'h02;
        host_rd(2'd0);
        chk("R8 status byte", rd_data, 8'h02);
        chk("R8 ack first", bus_ack, 1);
        bus_req = 1'b0;
        step();
        chk("R8 ack gap", bus_ack, 0);
        bus_data_in = 8'h77;
        bus_req = 1'b1;
        step();
        chk("R8 message ack", bus_ack, 1);
        chk("R8 message hidden", rd_data, 8'h02);
        bus_req = 1'b0;
        step();
        chk("R8 message done", bus_ack, 0);
        bus_req = 1'b1;
        step();
        chk("R8 no completion irq", irq, 0);
        bus_idle();
    endtask

    task automatic t_collision();
        bus_set(1, 0, 0, 1);
        host_wr(2'd0, 8'h3C);
        bus_req = 1'b0;
        step();
        bus_set(1, 1, 1, 1);
        host_rd(2'd1);
        chk("R4 collide old flag", rd_data[5], 0);
        chk("R4 collide set wins", irq, 1);
        host_rd(2'd1);
        chk("R4 flag kept", rd_data, 8'hEF);
        bus_idle();
    endtask

    task automatic t_reset_write();
        int n;
        host_wr(2'd3, 8'h03);
        bus_set(1, 0, 1, 1);
        host_rd(2'd0);
        chk("R9 hs started", bus_ack, 1);
        host_wr(2'd1, 8'h00);
        chk("R9 abort ack", bus_ack, 0);
        n = 0;
        while (bus_rst && n < 100) begin n++; step(); end
        chk("R9 rst width", n, RST_CYC);
        host_rd(2'd1);
        chk("R9 mask cleared", rd_data, 8'hCB);
        chk("R9 no irq", irq, 0);
        bus_idle();
    endtask

    task automatic t_select();
        int n;
        host_wr(2'd2, 8'h00);
        chk("R10 sel", bus_sel, 1);
        chk("R10 oe", bus_data_oe, 1);
        chk("R10 id byte", bus_data_out, 8'h01);
        n = 0;
        while (bus_sel && n < 100) begin n++; step(); end
        chk("R10 sel width", n, SEL_CYC);
        chk("R10 released oe", bus_data_oe, 0);
    endtask

    task automatic t_timeout();
        int n;
        bus_set(1, 0, 1, 1);
        host_rd(2'd0);
        n = 0;
        while (bus_ack && n < 1000) begin n++; step(); end
        chk("R14 timeout length", n, TO_CYC);
        step();
        chk("R14 stays idle", bus_ack, 0);
        bus_idle();
    endtask

    task automatic report();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual hung expected done");
            report();
            $finish;
        end
    end

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        t_reset();
        t_status();
        t_mask_dreq();
        t_config();
        t_data_read();
        t_write_done();
        t_status_read();
        t_collision();
        t_reset_write();
        t_select();
        t_timeout();
        finished = 1'b1;
        report();
        $finish;
    end
endmodule